// File: doc/BRIEF.md
# Serial Shift Engine with Inter-Frame Wait

This block is a register-programmed serial shift engine that can act as clock master or as clock-following slave. It handles frames of 1 to 32 bits, most significant bit first. In master mode every frame starts with a CPU write to the transmit register. The written value may be real data or filler when only reception is wanted. After each frame the engine holds its serial clock at the idle level for a programmable number of divided-clock periods before it starts the next queued frame. In slave mode the engine follows an external serial clock while slave select is low, and it needs no transmit write to receive.

A finished frame lands right-aligned in the receive register and raises a ready flag. If the previous word has not been read, the engine also raises an overrun flag. One CPU read of the receive register clears both flags. The ready flag can drive an interrupt line, a DMA request line, or both. The overrun flag has its own interrupt line.

Register map on the two-bit CPU address. Address 0 reads the received word. Address 1 is written with transmit data and reads status {busy, overrun, ready} in bits [2:0]. Address 2 is control: bit 0 enable, bit 1 master, bit 2 idle clock level (polarity), bit 3 phase, bit 4 DMA enable, bit 5 ready interrupt enable, bit 6 overrun interrupt enable, and bits [12:8] frame length minus one. Address 3 is timing: bits [7:0] divider D and bits [15:8] wait W.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset all registers read 0, status is 0, `sclk_o` is 0 and `irq_rx`, `irq_ovf` and `dma_req` are low.
- R2: In master mode a write to address 1 starts exactly one frame of (length field + 1) bits. The frame shifts the transmit word out on `sdo` MSB first and samples `sdi`. With no write, `sclk_o` never leaves its idle level.
- R3: When a frame completes, the received bits are stored right-aligned at address 0 with zeros above them, and status bit 0 (ready) becomes 1.
- R4: A read of address 0 clears status bit 0 (ready) and status bit 1 (overrun).
- R5: If a frame completes while ready is 1, status bit 1 (overrun) becomes 1 and address 0 holds the newest word.
- R6: In master mode `sclk_o` changes every D+1 system cycles during a frame and rests at the polarity bit when idle. Phase 0 samples on the leading edge and shifts on the trailing edge. Phase 1 shifts on the leading edge and samples on the trailing edge.
- R7: For queued back-to-back master frames, the interval from the last trailing edge of one frame to the first leading edge of the next is (D+1)*(2W+3) system cycles, so the gap is W+1 full clock periods longer than a half period. `sclk_o` stays idle during it.
- R8: Status bit 2 (busy) is 1 from a master transmit write until the wait after the last queued frame has expired.
- R9: In slave mode, while `ss_n_i` is low, the engine receives on edges of `sclk_i` with no transmit write and shifts the transmit register out on `sdo`, in both phases.
- R10: `irq_rx` equals ready AND bit 5, `irq_ovf` equals overrun AND bit 6, and `dma_req` equals ready AND bit 4.
- R11: With enable 0, a transmit write starts no frame, `sclk_o` stays idle and no word is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (address 0 clears flags) |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, combinational on address |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_i | input | 1 | Serial clock received in slave mode |
| ss_n_i | input | 1 | Active-low slave select in slave mode |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |
| irq_rx | output | 1 | Received-data interrupt |
| irq_ovf | output | 1 | Overrun interrupt |
| dma_req | output | 1 | Receive DMA request |

## Verification
The hardest situation to reach is the inter-frame wait. It occurs only when a second transmit write is already queued before the first frame ends. The gap must then be measured from a trailing clock edge to the next leading edge. The stimulus issues two transmit writes in a row with `sdo` looped back to `sdi`, counts cycles between `sclk_o` transitions, and leaves the first word unread so that the same run also produces an overrun. Slave mode is driven by a slow bench-side clock that samples `sdo` on the edges the phase setting implies.

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int DW     = 32,
  parameter int DIV_W  = 8,
  parameter int WAIT_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          sclk_o,
  input  logic          sclk_i,
  input  logic          ss_n_i,
  output logic          sdo,
  input  logic          sdi,
  output logic          irq_rx,
  output logic          irq_ovf,
  output logic          dma_req
);
  localparam int LW = $clog2(DW);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_GAP} st_t;

  logic en, master, cpol, cpha, dma_en, rx_ie, ovf_ie;
  logic [LW-1:0]     len_m1;
  logic [DIV_W-1:0]  div;
  logic [WAIT_W-1:0] wt;
  logic [DW-1:0]     txd, rxd, tx_sh;
  logic [DW-2:0]     rx_sh;
  logic [LW-1:0]     smp_cnt;
  logic [DIV_W-1:0]  dcnt;
  logic [WAIT_W:0]   gcnt;
  logic [2:0]        sc_s;
  logic [1:0]        ss_s;
  logic full, ovf, pend, sclk_q, last_q, sdo_q;
  st_t  state;

  wire rd_clr  = cpu_rd && cpu_addr == 2'd0;
  wire tx_wr   = cpu_wr && cpu_addr == 2'd1;
  wire m_en    = en && master;
  wire s_act   = en && !master && !ss_s[1];
  wire tick    = state != ST_IDLE && dcnt == div;
  wire gap_end = state == ST_GAP && tick && gcnt == {wt, 1'b1};
  wire start   = m_en && pend && (state == ST_IDLE || gap_end);
  wire m_lead  = state == ST_RUN && tick && !sclk_q;
  wire m_trail = state == ST_RUN && tick && sclk_q;
  wire s_lead  = s_act && (sc_s[1] ^ cpol) && !(sc_s[2] ^ cpol);
  wire s_trail = s_act && !(sc_s[1] ^ cpol) && (sc_s[2] ^ cpol);
  wire lead    = master ? m_lead : s_lead;
  wire trail   = master ? m_trail : s_trail;
  wire smp_ev  = cpha ? trail : lead;
  wire drv_ev  = cpha ? lead : trail;
  wire load    = m_en ? start : !s_act;
  wire done    = smp_ev && smp_cnt == len_m1;
  wire [DW-1:0] rx_nxt = {rx_sh, sdi};
  wire busy    = m_en && (pend || state != ST_IDLE);

  assign sclk_o  = m_en ? (sclk_q ^ cpol) : cpol;
  assign sdo     = sdo_q;
  assign irq_rx  = full && rx_ie;
  assign irq_ovf = ovf && ovf_ie;
  assign dma_req = full && dma_en;

  always_comb begin
    case (cpu_addr)
      2'd0:    cpu_rdata = rxd;
      2'd1:    cpu_rdata = {{(DW-3){1'b0}}, busy, ovf, full};
      2'd2:    cpu_rdata = {{(DW-8-LW){1'b0}}, len_m1, 1'b0, ovf_ie, rx_ie, dma_en, cpha, cpol, master, en};
      default: cpu_rdata = {{(DW-DIV_W-WAIT_W){1'b0}}, wt, div};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, master, cpol, cpha, dma_en, rx_ie, ovf_ie} <= '0;
      len_m1 <= '0;
      div    <= '0;
      wt     <= '0;
      txd    <= '0;
    end else if (cpu_wr) begin
      case (cpu_addr)
        2'd1: txd <= cpu_wdata;
        2'd2: begin
          {ovf_ie, rx_ie, dma_en, cpha, cpol, master, en} <= cpu_wdata[6:0];
          len_m1 <= cpu_wdata[8 +: LW];
        end
        2'd3: begin
          div <= cpu_wdata[0 +: DIV_W];
          wt  <= cpu_wdata[DIV_W +: WAIT_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_s <= '0;
      ss_s <= '1;
    end else begin
      sc_s <= {sc_s[1:0], sclk_i};
      ss_s <= {ss_s[0], ss_n_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      sclk_q <= 1'b0;
      last_q <= 1'b0;
      dcnt   <= '0;
      gcnt   <= '0;
    end else if (!m_en) begin
      state  <= ST_IDLE;
      pend   <= 1'b0;
      sclk_q <= 1'b0;
      last_q <= 1'b0;
      dcnt   <= '0;
      gcnt   <= '0;
    end else begin
      if (tx_wr)      pend <= 1'b1;
      else if (start) pend <= 1'b0;
      dcnt <= (state == ST_IDLE || start || tick) ? '0 : dcnt + 1'b1;
      if (m_lead)  sclk_q <= 1'b1;
      if (m_trail) sclk_q <= 1'b0;
      if (state != ST_RUN || m_trail) last_q <= 1'b0;
      else if (done)                  last_q <= 1'b1;
      case (state)
        ST_IDLE: if (start) state <= ST_RUN;
        ST_RUN: if (m_trail && (done || last_q)) begin
          state <= ST_GAP;
          gcnt  <= '0;
        end
        ST_GAP: if (gap_end) state <= start ? ST_RUN : ST_IDLE;
                else if (tick) gcnt <= gcnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      smp_cnt <= '0;
      sdo_q   <= 1'b0;
    end else if (load) begin
      rx_sh   <= '0;
      smp_cnt <= '0;
      if (cpha) tx_sh <= txd;
      else begin
        sdo_q <= txd[len_m1];
        tx_sh <= txd << 1;
      end
    end else begin
      if (smp_ev) begin
        rx_sh   <= done ? '0 : rx_nxt[DW-2:0];
        smp_cnt <= done ? '0 : smp_cnt + 1'b1;
      end
      if (drv_ev) begin
        sdo_q <= tx_sh[len_m1];
        tx_sh <= tx_sh << 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxd  <= '0;
      full <= 1'b0;
      ovf  <= 1'b0;
    end else if (done) begin
      rxd  <= rx_nxt;
      full <= 1'b1;
      if (full && !rd_clr) ovf <= 1'b1;
      else if (rd_clr)     ovf <= 1'b0;
    end else if (rd_clr) begin
      full <= 1'b0;
      ovf  <= 1'b0;
    end
  end

  a_r3_done_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> full);
  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    done && full && !rd_clr |=> ovf);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr && !done |=> !full && !ovf);
  a_r7_gap_idle_clock: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_GAP |-> sclk_o == cpol);
  a_r2_no_write_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE && !pend |=> state != ST_RUN);
  a_r11_off_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state == ST_IDLE);
endmodule

// File: tb/sim_spi_frame_engine.sv
module sim_spi_frame_engine;
  localparam int CLK_P = 10;
  localparam int H = 8;

  typedef struct packed {
    logic        cpha;
    logic        cpol;
    logic [4:0]  lm1;
    logic [7:0]  div;
    logic [7:0]  wt;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 5'd7,  8'd0, 8'd0, 32'h0000_00A5},
    '{1'b1, 1'b0, 5'd7,  8'd1, 8'd2, 32'h0000_003C},
    '{1'b0, 1'b1, 5'd15, 8'd2, 8'd0, 32'h0000_BEEF},
    '{1'b1, 1'b1, 5'd31, 8'd0, 8'd1, 32'h8001_7FFE},
    '{1'b0, 1'b0, 5'd3,  8'd0, 8'd0, 32'hFFFF_FFFF},
    '{1'b1, 1'b0, 5'd0,  8'd3, 8'd0, 32'h0000_0001}
  };

  logic clk = 0, rst_n = 0;
  logic [1:0] cpu_addr = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic sclk_o, sclk_i = 0, ss_n_i = 1, sdo, sdi, sdi_drv = 0, lb = 0;
  logic irq_rx, irq_ovf, dma_req;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  assign sdi = lb ? sdo : sdi_drv;
  always #(CLK_P/2) clk = ~clk;

  spi_frame_engine u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sclk_o(sclk_o), .sclk_i(sclk_i),
    .ss_n_i(ss_n_i), .sdo(sdo), .sdi(sdi), .irq_rx(irq_rx), .irq_ovf(irq_ovf), .dma_req(dma_req));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1; #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  function automatic logic [31:0] ctl(input logic m, input logic pol, input logic ph,
                                      input logic dma, input logic rie, input logic oie,
                                      input logic [4:0] lm1);
    return {19'd0, lm1, 1'b0, oie, rie, dma, ph, pol, m, 1'b1};
  endfunction

  task automatic wait_toggle(output int cyc);
    logic prev;
    prev = sclk_o; cyc = 0;
    do begin @(negedge clk); cyc++; end while (sclk_o == prev && cyc < 5000);
  endtask

  task automatic poll(input int bitpos, input logic val);
    logic [31:0] st;
    rd(2'd1, st);
    for (int i = 0; i < 3000 && st[bitpos] != val; i++) rd(2'd1, st);
  endtask

  task automatic slave_xfer(input logic ph, input logic pol, input logic [7:0] din,
                            output logic [7:0] dout);
    sclk_i = pol; repeat (H) @(negedge clk);
    ss_n_i = 0; repeat (H) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      if (!ph) begin
        sdi_drv = din[i]; repeat (H) @(negedge clk);
        sclk_i = !pol; dout[i] = sdo; repeat (H) @(negedge clk);
        sclk_i = pol;
      end else begin
        sclk_i = !pol; sdi_drv = din[i]; repeat (H) @(negedge clk);
        sclk_i = pol; dout[i] = sdo; repeat (H) @(negedge clk);
      end
    end
    repeat (H) @(negedge clk);
    ss_n_i = 1; repeat (H) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, mask;
    logic [7:0] so;
    int cyc, tog;

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, d); check("R1 rx", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 ctrl", d, 0);
    check("R1 pins", {sclk_o, irq_rx, irq_ovf, dma_req}, 0);

    // vector table: loopback master frames, R2 R3 R4 R6
    lb = 1;
    foreach (VEC[k]) begin
      mask = (VEC[k].lm1 == 5'd31) ? 32'hFFFF_FFFF : ((32'd1 << (VEC[k].lm1 + 1)) - 1);
      wr(2'd2, ctl(1, VEC[k].cpol, VEC[k].cpha, 0, 0, 0, VEC[k].lm1));
      wr(2'd3, {16'd0, VEC[k].wt, VEC[k].div});
      wr(2'd1, VEC[k].data);
      poll(0, 1'b1);
      rd(2'd0, d); check("R3 R2 loopback word", d, VEC[k].data & mask);
      rd(2'd1, d); check("R4 ready cleared", d & 32'h3, 0);
      poll(2, 1'b0);
      check("R6 idle level", sclk_o, VEC[k].cpol);
    end

    // R6 R7 R8 R5: back-to-back frames, divider 3, wait 1
    wr(2'd2, ctl(1, 0, 0, 0, 0, 1, 5'd7));
    wr(2'd3, {16'd0, 8'd1, 8'd3});
    wr(2'd1, 32'h3C);
    rd(2'd1, d); check("R8 busy after write", d[2], 1);
    wr(2'd1, 32'hC3);
    wait_toggle(cyc);
    wait_toggle(cyc); check("R6 half period", cyc, 4);
    for (int i = 0; i < 14; i++) wait_toggle(cyc);
    wait_toggle(cyc); check("R7 inter-frame gap", cyc, 20);
    check("R7 leading level", sclk_o, 1);
    poll(2, 1'b0);
    rd(2'd1, d); check("R5 overrun and ready", d, 32'h3);
    check("R10 irq_ovf", irq_ovf, 1);
    rd(2'd0, d); check("R5 newest word", d, 32'hC3);
    rd(2'd1, d); check("R4 both flags cleared", d, 0);
    check("R10 irq_ovf low", irq_ovf, 0);

    // R2: no write, no clock
    tog = 0;
    for (int i = 0; i < 300; i++) begin
      logic p;
      p = sclk_o; @(negedge clk);
      if (sclk_o != p) tog++;
    end
    check("R2 no frame without write", tog, 0);

    // R10 DMA and ready interrupt
    wr(2'd2, ctl(1, 0, 1, 1, 1, 0, 5'd7));
    wr(2'd1, 32'h5A);
    poll(0, 1'b1);
    check("R10 dma_req and irq_rx", {dma_req, irq_rx}, 2'b11);
    rd(2'd0, d);
    check("R10 dma_req and irq_rx after read", {dma_req, irq_rx}, 2'b00);
    wr(2'd2, ctl(1, 0, 1, 0, 0, 0, 5'd7));
    wr(2'd1, 32'h11);
    poll(0, 1'b1);
    check("R10 dma off", dma_req, 0);
    rd(2'd0, d);

    // R11 disabled block
    wr(2'd2, 32'h0000_0702);
    wr(2'd1, 32'hFF);
    tog = 0;
    for (int i = 0; i < 300; i++) begin
      logic p;
      p = sclk_o; @(negedge clk);
      if (sclk_o != p) tog++;
    end
    check("R11 no clock when off", tog, 0);
    rd(2'd1, d); check("R11 no word when off", d, 0);

    // R9 slave, both phases
    lb = 0;
    wr(2'd2, {ctl(0, 0, 0, 0, 0, 0, 5'd7)});
    wr(2'd1, 32'h5A);
    slave_xfer(0, 0, 8'h96, so);
    rd(2'd0, d); check("R9 slave rx phase 0", d, 32'h96);
    check("R9 slave tx phase 0", so, 8'h5A);
    wr(2'd2, {ctl(0, 1, 1, 0, 0, 0, 5'd7)});
    wr(2'd1, 32'hE1);
    slave_xfer(1, 1, 8'h2B, so);
    rd(2'd0, d); check("R9 slave rx phase 1", d, 32'h2B);
    check("R9 slave tx phase 1", so, 8'hE1);
    rd(2'd1, d); check("R9 R4 slave flags cleared", d, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule